// File: doc/BRIEF.md
# Card Interface Control and Status Register Bank

This block is the register file of a memory-card host controller. A simple single-cycle bus reaches it: a select, a write flag, a 12-bit byte address and 32-bit write data. It holds the setup words the command and data engines read, and it shows the read-only values those engines report. It keeps a status word and raises two interrupt lines from it.

The low eleven status bits are sticky event flags. Pulses from the command and data engines set them. Software clears them by writing ones to a separate clear register. Status bits 21 to 11 are live FIFO and activity flags that the data engine drives straight through. Each interrupt line is the OR of the status word ANDed with its own mask register. A fixed eight-byte identification block sits at the top of the 4 KB map, one byte per word. A sixteen-word window passes FIFO reads and writes on to the data engine as one-cycle strobes.

Top module: `cardif_csr`

## Requirements
- R1: After reset every stored register (power, clock, argument, command, data timer, data length, data control, both masks) reads 0. The sticky status is 0, both interrupt lines are low and `bus_rdata`, `bus_err`, `fifo_pop` and `fifo_push` are 0.
- R2: The argument (0x08), command (0x0C), data timer (0x24), mask0 (0x3C) and mask1 (0x40) registers store all 32 written bits. They drive their outputs on the cycle after the write. A read returns its data on `bus_rdata` one cycle after the read access.
- R3: The power (0x00), clock (0x04) and data-control (0x2C) registers keep only write bits [7:0]. Data length (0x28) keeps only bits [15:0]. The upper bits read as 0.
- R4: A 1 on bit k of `evt_set` (k from 0 to 10) sets status bit k (status at 0x34) one cycle later. The bit then stays set until it is cleared.
- R5: A write to the clear register (0x38) clears each status bit in [10:0] that is written as 1. Bits written as 0 are left unchanged. Write bits [31:11] have no effect, and the clear register reads 0.
- R6: When the same status bit is set by `evt_set` and cleared by the bus in the same cycle, the set wins.
- R7: Status bits [21:11] show `live_flags` [10:0] as they are now, without holding them. Status bits [31:22] read 0, and a write to 0x34 changes nothing.
- R8: `irq_line[i]` is high exactly when (status AND mask_i) is nonzero. It follows the status with no added delay.
- R9: Reads from 0xFE0 to 0xFFF return, at word index (offset-0xFE0)>>2, the bytes 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in the low 8 bits.
- R10: Offsets 0x10 (response command, 6 bits), 0x14/0x18/0x1C/0x20 (response words 0 to 3), 0x30 (data count, 16 bits) and 0x48 (FIFO count, 16 bits) read the matching input ports. Writes to these offsets are ignored.
- R11: A read in the window 0x80 to 0xBC returns `fifo_rdata` and pulses `fifo_pop` on the next cycle. A write there pulses `fifo_push` on the next cycle, with the data on `fifo_wdata`.
- R12: An access to an undefined offset, or to an address with bits [1:0] not zero, reads 0 and changes no register. It pulses `bus_err` for one cycle, on the cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| bus_err | output | 1 | Decode-error pulse |
| evt_set | input | 11 | Sticky status set pulses |
| live_flags | input | 11 | Live status flags for bits [21:11] |
| resp_cmd | input | 6 | Response command index |
| resp_word | input | 4x32 | Response words 3..0 |
| data_cnt | input | 16 | Remaining data count |
| fifo_cnt | input | 16 | Remaining FIFO word count |
| fifo_rdata | input | 32 | FIFO head word |
| fifo_pop | output | 1 | FIFO read strobe |
| fifo_push | output | 1 | FIFO write strobe |
| fifo_wdata | output | 32 | FIFO write word |
| pwr_ctrl | output | 8 | Power register |
| clk_ctrl | output | 8 | Clock register |
| cmd_arg | output | 32 | Command argument |
| cmd_word | output | 32 | Command register |
| dto_limit | output | 32 | Data timer |
| xfer_len | output | 16 | Data length |
| xfer_ctrl | output | 8 | Data control |
| irq_line | output | 2 | Masked interrupt lines |

## Verification
A write takes effect on the next rising edge. Register outputs, sticky status bits and the decode-error and FIFO strobes all come from flops, so each is due exactly one edge after its stimulus. Read data also comes from a flop and is due one edge after the read access. The interrupt lines and the live status bits add no delay on top of the status flop or the `live_flags` input. The bench drives each stimulus on a falling edge and samples on the next falling edge, halfway past the single rising edge that must produce the result. Strobes are checked again one cycle later to show they have dropped.

// File: rtl/cardif_csr_pkg.sv
package cardif_csr_pkg;

  localparam int CSR_AW   = 12;
  localparam int CSR_DW   = 32;
  localparam int STICKY_W = 11;
  localparam int LIVE_W   = 11;
  localparam int NIRQ     = 2;

  typedef enum logic [4:0] {
    RG_NONE, RG_POWER, RG_CLOCK, RG_ARG, RG_CMD, RG_RCMD, RG_RESP,
    RG_DTIMER, RG_DLEN, RG_DCTRL, RG_DCNT, RG_STATUS, RG_CLEAR,
    RG_MASK, RG_FCNT, RG_FIFO, RG_ID
  } region_e;

  typedef struct packed {
    region_e    region;
    logic [2:0] idx;
  } decode_t;

  function automatic logic [7:0] id_byte(input logic [2:0] i);
    case (i)
      3'd0: id_byte = 8'h81;
      3'd1: id_byte = 8'h11;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/cardif_csr_decode.sv
module cardif_csr_decode
  import cardif_csr_pkg::*;
(
  input  logic [CSR_AW-1:0] addr,
  output decode_t           dec
);

  always_comb begin
    dec.region = RG_NONE;
    dec.idx    = addr[4:2];
    if (addr[1:0] != 2'b00) begin
      dec.region = RG_NONE;
    end else if (addr[11:5] == 7'h7F) begin
      dec.region = RG_ID;
    end else if (addr[11:6] == 6'b000010) begin
      dec.region = RG_FIFO;
    end else begin
      case (addr)
        12'h000: dec.region = RG_POWER;
        12'h004: dec.region = RG_CLOCK;
        12'h008: dec.region = RG_ARG;
        12'h00C: dec.region = RG_CMD;
        12'h010: dec.region = RG_RCMD;
        12'h014: begin dec.region = RG_RESP; dec.idx = 3'd0; end
        12'h018: begin dec.region = RG_RESP; dec.idx = 3'd1; end
        12'h01C: begin dec.region = RG_RESP; dec.idx = 3'd2; end
        12'h020: begin dec.region = RG_RESP; dec.idx = 3'd3; end
        12'h024: dec.region = RG_DTIMER;
        12'h028: dec.region = RG_DLEN;
        12'h02C: dec.region = RG_DCTRL;
        12'h030: dec.region = RG_DCNT;
        12'h034: dec.region = RG_STATUS;
        12'h038: dec.region = RG_CLEAR;
        12'h03C: begin dec.region = RG_MASK; dec.idx = 3'd0; end
        12'h040: begin dec.region = RG_MASK; dec.idx = 3'd1; end
        12'h048: dec.region = RG_FCNT;
        default: dec.region = RG_NONE;
      endcase
    end
  end

endmodule

// File: rtl/cardif_csr_status.sv
module cardif_csr_status #(
  parameter int STICKY_W = 11,
  parameter int LIVE_W   = 11,
  parameter int DW       = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [STICKY_W-1:0] set_i,
  input  logic [STICKY_W-1:0] clr_i,
  input  logic [LIVE_W-1:0]   live_i,
  output logic [DW-1:0]       status_o
);

  logic [STICKY_W-1:0] sticky_q, sticky_d;
  logic                sticky_en;

  always_comb begin
    sticky_en = (|set_i) | (|clr_i);
    sticky_d  = (sticky_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sticky_q <= '0;
    else if (sticky_en) sticky_q <= sticky_d;
  end

  assign status_o = DW'({live_i, sticky_q});

  // R4 R6
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((sticky_q & $past(set_i)) == $past(set_i)));

  // R5
  sticky_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((sticky_q & $past(clr_i & ~set_i)) == '0));

  // R5
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sticky_q & ~clr_i)) |=>
      ((sticky_q & $past(sticky_q & ~clr_i)) == $past(sticky_q & ~clr_i)));

endmodule

// File: rtl/cardif_csr_irq.sv
module cardif_csr_irq #(
  parameter int NIRQ = 2,
  parameter int DW   = 32
) (
  input  logic [DW-1:0]            status_i,
  input  logic [NIRQ-1:0][DW-1:0]  mask_i,
  output logic [NIRQ-1:0]          irq_o
);

  for (genvar g = 0; g < NIRQ; g++) begin : g_line
    assign irq_o[g] = |(status_i & mask_i[g]);
  end

endmodule

// File: rtl/cardif_csr.sv
module cardif_csr
  import cardif_csr_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_sel,
  input  logic                   bus_wr,
  input  logic [11:0]            bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  output logic                   bus_err,
  input  logic [10:0]            evt_set,
  input  logic [10:0]            live_flags,
  input  logic [5:0]             resp_cmd,
  input  logic [3:0][31:0]       resp_word,
  input  logic [15:0]            data_cnt,
  input  logic [15:0]            fifo_cnt,
  input  logic [31:0]            fifo_rdata,
  output logic                   fifo_pop,
  output logic                   fifo_push,
  output logic [31:0]            fifo_wdata,
  output logic [7:0]             pwr_ctrl,
  output logic [7:0]             clk_ctrl,
  output logic [31:0]            cmd_arg,
  output logic [31:0]            cmd_word,
  output logic [31:0]            dto_limit,
  output logic [15:0]            xfer_len,
  output logic [7:0]             xfer_ctrl,
  output logic [1:0]             irq_line
);

  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;

  decode_t dec;
  logic    wr_acc, rd_acc;

  logic [BYTE_W-1:0]          pwr_d, clkc_d, xctl_d;
  logic [HALF_W-1:0]          xlen_d;
  logic [CSR_DW-1:0]          arg_d, cmd_d, dto_d;
  logic [NIRQ-1:0][CSR_DW-1:0] mask_q, mask_d;
  logic [CSR_DW-1:0]          rd_mux, rdata_q, fwd_q, status;
  logic [STICKY_W-1:0]        clr_vec;
  logic                       err_q, pop_q, push_q;

  cardif_csr_decode u_dec (.addr(bus_addr), .dec(dec));

  assign wr_acc = bus_sel & bus_wr;
  assign rd_acc = bus_sel & ~bus_wr;

  // next-state for stored setup registers
  always_comb begin
    pwr_d  = pwr_ctrl;
    clkc_d = clk_ctrl;
    arg_d  = cmd_arg;
    cmd_d  = cmd_word;
    dto_d  = dto_limit;
    xlen_d = xfer_len;
    xctl_d = xfer_ctrl;
    mask_d = mask_q;
    clr_vec = '0;
    if (wr_acc) begin
      case (dec.region)
        RG_POWER:  pwr_d  = bus_wdata[BYTE_W-1:0];
        RG_CLOCK:  clkc_d = bus_wdata[BYTE_W-1:0];
        RG_ARG:    arg_d  = bus_wdata;
        RG_CMD:    cmd_d  = bus_wdata;
        RG_DTIMER: dto_d  = bus_wdata;
        RG_DLEN:   xlen_d = bus_wdata[HALF_W-1:0];
        RG_DCTRL:  xctl_d = bus_wdata[BYTE_W-1:0];
        RG_MASK:   mask_d[dec.idx[0]] = bus_wdata;
        RG_CLEAR:  clr_vec = bus_wdata[STICKY_W-1:0];
        default: ;
      endcase
    end
  end

  // read multiplexer
  always_comb begin
    rd_mux = '0;
    case (dec.region)
      RG_POWER:  rd_mux = CSR_DW'(pwr_ctrl);
      RG_CLOCK:  rd_mux = CSR_DW'(clk_ctrl);
      RG_ARG:    rd_mux = cmd_arg;
      RG_CMD:    rd_mux = cmd_word;
      RG_RCMD:   rd_mux = CSR_DW'(resp_cmd);
      RG_RESP:   rd_mux = resp_word[dec.idx[1:0]];
      RG_DTIMER: rd_mux = dto_limit;
      RG_DLEN:   rd_mux = CSR_DW'(xfer_len);
      RG_DCTRL:  rd_mux = CSR_DW'(xfer_ctrl);
      RG_DCNT:   rd_mux = CSR_DW'(data_cnt);
      RG_STATUS: rd_mux = status;
      RG_MASK:   rd_mux = mask_q[dec.idx[0]];
      RG_FCNT:   rd_mux = CSR_DW'(fifo_cnt);
      RG_FIFO:   rd_mux = fifo_rdata;
      RG_ID:     rd_mux = CSR_DW'(id_byte(dec.idx));
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_ctrl  <= '0;
      clk_ctrl  <= '0;
      cmd_arg   <= '0;
      cmd_word  <= '0;
      dto_limit <= '0;
      xfer_len  <= '0;
      xfer_ctrl <= '0;
      mask_q    <= '0;
    end else if (wr_acc) begin
      pwr_ctrl  <= pwr_d;
      clk_ctrl  <= clkc_d;
      cmd_arg   <= arg_d;
      cmd_word  <= cmd_d;
      dto_limit <= dto_d;
      xfer_len  <= xlen_d;
      xfer_ctrl <= xctl_d;
      mask_q    <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_acc) rdata_q <= rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      pop_q  <= 1'b0;
      push_q <= 1'b0;
    end else begin
      err_q  <= bus_sel & (dec.region == RG_NONE);
      pop_q  <= rd_acc & (dec.region == RG_FIFO);
      push_q <= wr_acc & (dec.region == RG_FIFO);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  fwd_q <= '0;
    else if (wr_acc && dec.region == RG_FIFO)    fwd_q <= bus_wdata;
  end

  cardif_csr_status #(.STICKY_W(STICKY_W), .LIVE_W(LIVE_W), .DW(CSR_DW)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_i(evt_set), .clr_i(clr_vec),
    .live_i(live_flags), .status_o(status)
  );

  cardif_csr_irq #(.NIRQ(NIRQ), .DW(CSR_DW)) u_irq (
    .status_i(status), .mask_i(mask_q), .irq_o(irq_line)
  );

  assign bus_rdata  = rdata_q;
  assign bus_err    = err_q;
  assign fifo_pop   = pop_q;
  assign fifo_push  = push_q;
  assign fifo_wdata = fwd_q;

  // R12
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_sel));

  // R12
  err_rzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && !$past(bus_wr)) |-> (bus_rdata == '0));

  // R3
  pwr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && dec.region == RG_POWER) |=> (pwr_ctrl == $past(bus_wdata[7:0])));

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q[0] == '0) |-> !irq_line[0]);

  // R11
  fifo_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fifo_pop, fifo_push}));

endmodule

// File: tb/cardif_csr_bench.sv
module cardif_csr_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_err;
  logic [10:0] evt_set, live_flags;
  logic [5:0]  resp_cmd;
  logic [3:0][31:0] resp_word;
  logic [15:0] data_cnt, fifo_cnt;
  logic [31:0] fifo_rdata, fifo_wdata;
  logic        fifo_pop, fifo_push;
  logic [7:0]  pwr_ctrl, clk_ctrl, xfer_ctrl;
  logic [31:0] cmd_arg, cmd_word, dto_limit;
  logic [15:0] xfer_len;
  logic [1:0]  irq_line;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cardif_csr u_cardif_csr (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .evt_set(evt_set), .live_flags(live_flags),
    .resp_cmd(resp_cmd), .resp_word(resp_word), .data_cnt(data_cnt),
    .fifo_cnt(fifo_cnt), .fifo_rdata(fifo_rdata), .fifo_pop(fifo_pop),
    .fifo_push(fifo_push), .fifo_wdata(fifo_wdata), .pwr_ctrl(pwr_ctrl),
    .clk_ctrl(clk_ctrl), .cmd_arg(cmd_arg), .cmd_word(cmd_word),
    .dto_limit(dto_limit), .xfer_len(xfer_len), .xfer_ctrl(xfer_ctrl),
    .irq_line(irq_line)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d, output logic err);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    err = bus_err;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d, output logic err);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata; err = bus_err;
  endtask

  task automatic pulse_evt(input logic [10:0] b);
    @(negedge clk);
    evt_set = b;
    @(negedge clk);
    evt_set = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic e;
    chk("R1 rdata", bus_rdata, 0);
    chk("R1 irq", {30'b0, irq_line}, 0);
    chk("R1 strobes", {29'b0, bus_err, fifo_pop, fifo_push}, 0);
    chk("R1 outs", {pwr_ctrl, clk_ctrl, xfer_ctrl, 8'h0} | cmd_arg | cmd_word | dto_limit | {16'h0, xfer_len}, 0);
    bus_read(12'h03C, d, e); chk("R1 mask0", d, 0);
    bus_read(12'h040, d, e); chk("R1 mask1", d, 0);
    bus_read(12'h034, d, e); chk("R1 status", d, 0);
  endtask

  task automatic t_full_regs();
    logic [31:0] d; logic e;
    bus_write(12'h008, 32'hDEADBEEF, e); chk("R2 arg out", cmd_arg, 32'hDEADBEEF);
    bus_write(12'h00C, 32'h0000_0451, e); chk("R2 cmd out", cmd_word, 32'h451);
    bus_write(12'h024, 32'hFFFF_0001, e); chk("R2 dto out", dto_limit, 32'hFFFF0001);
    bus_read(12'h008, d, e); chk("R2 arg read", d, 32'hDEADBEEF);
    bus_read(12'h024, d, e); chk("R2 dto read", d, 32'hFFFF0001);
    chk("R2 no err", {31'b0, e}, 0);
  endtask

  task automatic t_width();
    logic [31:0] d; logic e;
    bus_write(12'h000, 32'hABCD_1234, e); chk("R3 power out", {24'b0, pwr_ctrl}, 32'h34);
    bus_write(12'h004, 32'hFFFF_FF5A, e);
    bus_write(12'h02C, 32'h1234_56C3, e);
    bus_write(12'h028, 32'h89AB_CDEF, e);
    bus_read(12'h000, d, e); chk("R3 power read", d, 32'h34);
    bus_read(12'h004, d, e); chk("R3 clock read", d, 32'h5A);
    bus_read(12'h02C, d, e); chk("R3 dctrl read", d, 32'hC3);
    bus_read(12'h028, d, e); chk("R3 dlen read", d, 32'hCDEF);
    chk("R3 dlen out", {16'b0, xfer_len}, 32'hCDEF);
  endtask

  task automatic t_sticky_clear();
    logic [31:0] d; logic e;
    live_flags = 11'h7FF;
    pulse_evt(11'h403);
    bus_read(12'h034, d, e); chk("R4 R7 set+live", d, 32'h003F_FC03);
    repeat (3) @(negedge clk);
    bus_read(12'h034, d, e); chk("R4 sticky held", d, 32'h003F_FC03);
    bus_write(12'h038, 32'hFFFF_F801, e);
    bus_read(12'h034, d, e); chk("R5 partial clear", d, 32'h003F_FC02);
    bus_write(12'h034, 32'hFFFF_FFFF, e);
    live_flags = 11'h005;
    bus_read(12'h034, d, e); chk("R7 live+ro", d, 32'h0000_2C02);
    bus_read(12'h038, d, e); chk("R5 clear reads 0", d, 0);
    bus_write(12'h038, 32'h0000_07FF, e);
    live_flags = '0;
    bus_read(12'h034, d, e); chk("R5 all clear", d, 0);
  endtask

  task automatic t_set_vs_clear();
    logic [31:0] d; logic e;
    pulse_evt(11'h004);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h038; bus_wdata = 32'h24;
    evt_set = 11'h020;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; evt_set = '0;
    bus_read(12'h034, d, e); chk("R6 set wins", d, 32'h20);
    bus_write(12'h038, 32'h7FF, e);
  endtask

  task automatic t_irq();
    logic e;
    bus_write(12'h03C, 32'h0000_0008, e);
    bus_write(12'h040, 32'h0000_1000, e);
    chk("R8 idle", {30'b0, irq_line}, 0);
    pulse_evt(11'h008);
    chk("R8 line0", {30'b0, irq_line}, 1);
    @(negedge clk); live_flags = 11'h002; #1;
    chk("R8 line1 live", {30'b0, irq_line}, 3);
    bus_write(12'h038, 32'h8, e);
    chk("R8 line0 cleared", {30'b0, irq_line}, 2);
    @(negedge clk); live_flags = '0; #1;
    chk("R8 both low", {30'b0, irq_line}, 0);
  endtask

  task automatic t_id();
    logic [31:0] d; logic e;
    logic [7:0] exp_id [8] = '{8'h81, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int i = 0; i < 8; i++) begin
      bus_read(12'hFE0 + 12'(i * 4), d, e);
      chk("R9 id byte", d, {24'b0, exp_id[i]});
    end
  endtask

  task automatic t_mirror();
    logic [31:0] d; logic e;
    resp_cmd = 6'h2A; data_cnt = 16'h0200; fifo_cnt = 16'h0080;
    resp_word = {32'h44444444, 32'h33333333, 32'h22222222, 32'h11111111};
    bus_write(12'h030, 32'hFFFF_FFFF, e);
    bus_read(12'h030, d, e); chk("R10 dcnt", d, 32'h200);
    bus_read(12'h010, d, e); chk("R10 rcmd", d, 32'h2A);
    bus_read(12'h014, d, e); chk("R10 resp0", d, 32'h11111111);
    bus_read(12'h020, d, e); chk("R10 resp3", d, 32'h44444444);
    bus_read(12'h048, d, e); chk("R10 fcnt", d, 32'h80);
    chk("R10 no err", {31'b0, e}, 0);
  endtask

  task automatic t_fifo();
    logic [31:0] d; logic e;
    fifo_rdata = 32'hCAFE_0001;
    bus_read(12'h084, d, e);
    chk("R11 fifo data", d, 32'hCAFE0001);
    chk("R11 pop", {30'b0, fifo_pop, fifo_push}, 2);
    @(negedge clk); chk("R11 pop drop", {31'b0, fifo_pop}, 0);
    bus_write(12'h0BC, 32'h1357_9BDF, e);
    chk("R11 push", {30'b0, fifo_pop, fifo_push}, 1);
    chk("R11 push data", fifo_wdata, 32'h13579BDF);
  endtask

  task automatic t_undef();
    logic [31:0] d; logic e;
    bus_write(12'h044, 32'hFFFF_FFFF, e); chk("R12 wr err", {31'b0, e}, 1);
    @(negedge clk); chk("R12 err drop", {31'b0, bus_err}, 0);
    bus_read(12'h044, d, e); chk("R12 rd zero", d, 0); chk("R12 rd err", {31'b0, e}, 1);
    bus_write(12'h00A, 32'h0, e); chk("R12 misaligned", {31'b0, e}, 1);
    bus_read(12'h008, d, e); chk("R12 arg kept", d, 32'hDEADBEEF);
    bus_read(12'hC00, d, e); chk("R12 hole", {d[30:0], e}, 1);
  endtask

  initial begin
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    evt_set = '0; live_flags = '0; resp_cmd = '0; resp_word = '0;
    data_cnt = '0; fifo_cnt = '0; fifo_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_regs();
    t_width();
    t_sticky_clear();
    t_set_vs_clear();
    t_irq();
    t_id();
    t_mirror();
    t_fifo();
    t_undef();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule